// File: doc/BRIEF.md
# Bulk Bitwise Row-Operation Dispatcher

This block sits between a memory controller and a resistive-cell memory that can compute bitwise functions over whole rows inside the arrays. A request names an operation, up to `MAX_OPS` operand row addresses and one destination row address. The block splits every address into chip, bank, subarray and row fields. It checks that the request can be served and then picks one of three execution places: the sense amplifiers of a single subarray, the logic beside the bank's global row buffer, or the logic beside the chip's I/O buffer.

A request that breaks a rule is accepted and dropped. One cycle later the block raises a single-cycle error pulse with a reason code, and it issues no micro-commands. A legal request becomes a short stream of micro-commands: wordline clear, row activate, hold-capture, sense, buffer load, buffer merge and result write. The stream ends with a write of the result, either in place through the subarray's write drivers or over the data bus. After the final command is taken, the block raises a one-cycle done pulse.

Both data-carrying edges are valid/ready. A request moves on a cycle in which `req_valid` and `req_ready` are both high. `req_ready` is high only while nothing is in flight. A command moves on a cycle in which `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is held low, the offered command stays unchanged and the sequence waits. `cmd_valid` does not depend on `cmd_ready`.

Top module: `bitop_dispatcher`

## Requirements
- R1: Addresses are packed as {chip, bank, subarray, row} from MSB to LSB, with widths CHIP_W, BANK_W, SUB_W and ROW_W. Only the first `req_cnt` entries of `req_srcs` are operands, and operand i sits at bits [i*ADDR_W +: ADDR_W].
- R2: Opcodes are READ=0, OR=1, AND=2, XOR=3 and INV=4. Any opcode from 5 to 7 is rejected with error code 1.
- R3: The other rejection codes are: 2 for an operand count that breaks the count rule, 3 for operands on more than one chip, and 4 for two operands with an identical address. When several rules are broken, the lowest code wins. A rejected request produces `err`=1 with its code in the cycle after acceptance, for one cycle only, and no micro-command.
- R4: When all operands share one bank and one subarray and the operation is not XOR, the commands are: CLR(src0), then ACT for each operand in list order, then SENSE(src0), then the result write. All carry unit 0.
- R5: An XOR within one subarray issues CLR(src0), ACT(src0), HOLD(src0), CLR(src0), ACT(src1), SENSE(src0) and then the result write, all on unit 0.
- R6: When all operands share one bank but span more than one subarray, the commands are LOAD(src0), then MERGE(src i) for i=1..cnt-1, then the result write, all on unit 1 (global row buffer).
- R7: When the operands span more than one bank of the same chip, the inter-buffer sequence of R6 is used on unit 2 (I/O buffer).
- R8: The result write is WB_LOCAL(dst) only when the request runs in one subarray and dst has the same chip, bank and subarray as the operands. Every other result write is WB_BUS(dst). Command kind codes are CLR=0, ACT=1, HOLD=2, SENSE=3, LOAD=4, MERGE=5, WB_LOCAL=6 and WB_BUS=7.
- R9: READ and INV take exactly one operand. AND and XOR take exactly two. OR takes from 2 to OR_MAX_ROWS operands. A wider AND is rejected, not split.
- R10: `req_ready` is low from the cycle after a legal request is accepted until the cycle after its last command is taken. Only one request is in flight at a time.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_kind`, `cmd_unit` and `cmd_addr` hold their values into the next cycle.
- R12: `done` is high for exactly one cycle, the cycle after the final command is taken. `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 3 | Operation code |
| req_cnt | input | CNT_W | Number of operand rows |
| req_srcs | input | MAX_OPS*ADDR_W | Operand row addresses, packed |
| req_dst | input | ADDR_W | Destination row address |
| cmd_valid | output | 1 | Micro-command offered |
| cmd_ready | input | 1 | Memory side takes the command |
| cmd_kind | output | 3 | Micro-command kind |
| cmd_unit | output | 2 | 0 sense array, 1 global row buffer, 2 I/O buffer |
| cmd_addr | output | ADDR_W | Row address the command acts on |
| cmd_func | output | 3 | Requested function, same code as req_op |
| done | output | 1 | One-cycle pulse after the final command |
| err | output | 1 | One-cycle rejection pulse |
| err_code | output | 3 | Rejection reason, 0 when err is low |

## Verification
The assertions check the handshake rules on every cycle. They check that the request side stays blocked while commands are pending, that a stalled command stays frozen, and that done and err pulses each follow their own handshake and never coincide. They also check that a rejection never comes with a command, and that buffer-side commands never target the sense array. Only the bench's scenarios can show the content of each sequence: which placement is chosen from the address fields, the order and addresses of the commands, the in-place versus bus write choice, and which reason code wins when several rules are broken at once.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam logic [2:0] OP_READ = 3'd0;
  localparam logic [2:0] OP_OR   = 3'd1;
  localparam logic [2:0] OP_AND  = 3'd2;
  localparam logic [2:0] OP_XOR  = 3'd3;
  localparam logic [2:0] OP_INV  = 3'd4;

  typedef enum logic [2:0] {
    K_CLR      = 3'd0,
    K_ACT      = 3'd1,
    K_HOLD     = 3'd2,
    K_SENSE    = 3'd3,
    K_LOAD     = 3'd4,
    K_MERGE    = 3'd5,
    K_WB_LOCAL = 3'd6,
    K_WB_BUS   = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    C_INTRA = 2'd0,
    C_SUB   = 2'd1,
    C_BANK  = 2'd2
  } place_e;

  localparam logic [1:0] U_ARRAY = 2'd0;
  localparam logic [1:0] U_GRB   = 2'd1;
  localparam logic [1:0] U_IOB   = 2'd2;

  localparam logic [2:0] E_NONE  = 3'd0;
  localparam logic [2:0] E_OPC   = 3'd1;
  localparam logic [2:0] E_COUNT = 3'd2;
  localparam logic [2:0] E_CHIP  = 3'd3;
  localparam logic [2:0] E_DUP   = 3'd4;

endpackage

// File: rtl/bitop_legality.sv
module bitop_legality
  import bitop_pkg::*;
#(
  parameter int CHIP_W      = 1,
  parameter int BANK_W      = 2,
  parameter int SUB_W       = 3,
  parameter int ROW_W       = 4,
  parameter int MAX_OPS     = 4,
  parameter int OR_MAX_ROWS = 3,
  localparam int ADDR_W     = CHIP_W + BANK_W + SUB_W + ROW_W,
  localparam int CNT_W      = $clog2(MAX_OPS + 1)
) (
  input  logic [2:0]                op,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [MAX_OPS*ADDR_W-1:0] srcs,
  input  logic [ADDR_W-1:0]         dst,
  output logic [2:0]                code,
  output place_e                    place,
  output logic                      local_wb
);

  localparam int SUB_LSB  = ROW_W;
  localparam int BANK_LSB = ROW_W + SUB_W;
  localparam int CHIP_LSB = ROW_W + SUB_W + BANK_W;

  logic [ADDR_W-1:0] src_a   [MAX_OPS];
  logic [CHIP_W-1:0] chip_f  [MAX_OPS];
  logic [BANK_W-1:0] bank_f  [MAX_OPS];
  logic [SUB_W-1:0]  sub_f   [MAX_OPS];

  for (genvar g = 0; g < MAX_OPS; g++) begin : g_field
    assign src_a[g]  = srcs[g*ADDR_W +: ADDR_W];
    assign chip_f[g] = src_a[g][CHIP_LSB +: CHIP_W];
    assign bank_f[g] = src_a[g][BANK_LSB +: BANK_W];
    assign sub_f[g]  = src_a[g][SUB_LSB +: SUB_W];
  end

  logic chip_diff, bank_diff, sub_diff, dup, count_ok;

  always_comb begin
    chip_diff = 1'b0;
    bank_diff = 1'b0;
    sub_diff  = 1'b0;
    dup       = 1'b0;
    for (int i = 1; i < MAX_OPS; i++) begin
      if (i < int'(cnt)) begin
        if (chip_f[i] != chip_f[0]) chip_diff = 1'b1;
        if (bank_f[i] != bank_f[0]) bank_diff = 1'b1;
        if (sub_f[i]  != sub_f[0])  sub_diff  = 1'b1;
      end
    end
    for (int i = 0; i < MAX_OPS; i++) begin
      for (int j = i + 1; j < MAX_OPS; j++) begin
        if (j < int'(cnt) && src_a[i] == src_a[j]) dup = 1'b1;
      end
    end
  end

  always_comb begin
    case (op)
      OP_READ, OP_INV: count_ok = (int'(cnt) == 1);
      OP_AND, OP_XOR:  count_ok = (int'(cnt) == 2);
      OP_OR:           count_ok = (int'(cnt) >= 2) && (int'(cnt) <= OR_MAX_ROWS);
      default:         count_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (op > OP_INV)   code = E_OPC;
    else if (!count_ok) code = E_COUNT;
    else if (chip_diff) code = E_CHIP;
    else if (dup)       code = E_DUP;
    else                code = E_NONE;
  end

  always_comb begin
    if (bank_diff)     place = C_BANK;
    else if (sub_diff) place = C_SUB;
    else               place = C_INTRA;
  end

  assign local_wb = (place == C_INTRA) &&
                    (dst[ADDR_W-1:SUB_LSB] == src_a[0][ADDR_W-1:SUB_LSB]);

endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int MAX_OPS = 4,
  localparam int CNT_W  = $clog2(MAX_OPS + 1),
  localparam int STEP_W = $clog2(MAX_OPS + 4)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [2:0]                op,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [MAX_OPS*ADDR_W-1:0] srcs,
  input  logic [ADDR_W-1:0]         dst,
  input  place_e                    place,
  input  logic                      local_wb,
  input  logic                      cmd_ready,
  output logic                      busy,
  output logic                      cmd_valid,
  output logic [2:0]                cmd_kind,
  output logic [1:0]                cmd_unit,
  output logic [ADDR_W-1:0]         cmd_addr,
  output logic [2:0]                cmd_func,
  output logic                      done
);

  logic              busy_q, done_q, lwb_q;
  logic [STEP_W-1:0] step_q, last_q, last_d;
  logic [2:0]        op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] src_q [MAX_OPS];
  logic [ADDR_W-1:0] dst_q;
  place_e            place_q;

  always_comb begin
    if (place != C_INTRA)   last_d = STEP_W'(cnt);
    else if (op == OP_XOR)  last_d = STEP_W'(6);
    else                    last_d = STEP_W'(int'(cnt) + 2);
  end

  wire take = busy_q && cmd_ready;
  wire fin  = take && (step_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      last_q  <= '0;
      op_q    <= OP_READ;
      cnt_q   <= '0;
      dst_q   <= '0;
      lwb_q   <= 1'b0;
      place_q <= C_INTRA;
      for (int i = 0; i < MAX_OPS; i++) src_q[i] <= '0;
    end else begin
      done_q <= fin;
      if (start && !busy_q) begin
        busy_q  <= 1'b1;
        step_q  <= '0;
        last_q  <= last_d;
        op_q    <= op;
        cnt_q   <= cnt;
        dst_q   <= dst;
        lwb_q   <= local_wb;
        place_q <= place;
        for (int i = 0; i < MAX_OPS; i++) src_q[i] <= srcs[i*ADDR_W +: ADDR_W];
      end else if (fin) begin
        busy_q <= 1'b0;
      end else if (take) begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  kind_e wb_kind;
  assign wb_kind = lwb_q ? K_WB_LOCAL : K_WB_BUS;

  always_comb begin
    cmd_kind = K_CLR;
    cmd_unit = U_ARRAY;
    cmd_addr = src_q[0];
    if (place_q == C_INTRA) begin
      if (op_q == OP_XOR) begin
        case (int'(step_q))
          0:       cmd_kind = K_CLR;
          1:       cmd_kind = K_ACT;
          2:       cmd_kind = K_HOLD;
          3:       cmd_kind = K_CLR;
          4: begin cmd_kind = K_ACT; cmd_addr = src_q[1]; end
          5:       cmd_kind = K_SENSE;
          default: begin cmd_kind = wb_kind; cmd_addr = dst_q; end
        endcase
      end else if (step_q == '0) begin
        cmd_kind = K_CLR;
      end else if (int'(step_q) <= int'(cnt_q)) begin
        cmd_kind = K_ACT;
        for (int i = 0; i < MAX_OPS; i++)
          if (int'(step_q) == i + 1) cmd_addr = src_q[i];
      end else if (int'(step_q) == int'(cnt_q) + 1) begin
        cmd_kind = K_SENSE;
      end else begin
        cmd_kind = wb_kind;
        cmd_addr = dst_q;
      end
    end else begin
      cmd_unit = (place_q == C_SUB) ? U_GRB : U_IOB;
      if (step_q == '0) begin
        cmd_kind = K_LOAD;
      end else if (int'(step_q) < int'(cnt_q)) begin
        cmd_kind = K_MERGE;
        for (int i = 1; i < MAX_OPS; i++)
          if (int'(step_q) == i) cmd_addr = src_q[i];
      end else begin
        cmd_kind = wb_kind;
        cmd_addr = dst_q;
      end
    end
  end

  assign busy      = busy_q;
  assign cmd_valid = busy_q;
  assign cmd_func  = op_q;
  assign done      = done_q;

endmodule

// File: rtl/bitop_dispatcher.sv
module bitop_dispatcher
  import bitop_pkg::*;
#(
  parameter int CHIP_W      = 1,
  parameter int BANK_W      = 2,
  parameter int SUB_W       = 3,
  parameter int ROW_W       = 4,
  parameter int MAX_OPS     = 4,
  parameter int OR_MAX_ROWS = 3,
  localparam int ADDR_W     = CHIP_W + BANK_W + SUB_W + ROW_W,
  localparam int CNT_W      = $clog2(MAX_OPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [2:0]                req_op,
  input  logic [CNT_W-1:0]          req_cnt,
  input  logic [MAX_OPS*ADDR_W-1:0] req_srcs,
  input  logic [ADDR_W-1:0]         req_dst,
  output logic                      cmd_valid,
  input  logic                      cmd_ready,
  output logic [2:0]                cmd_kind,
  output logic [1:0]                cmd_unit,
  output logic [ADDR_W-1:0]         cmd_addr,
  output logic [2:0]                cmd_func,
  output logic                      done,
  output logic                      err,
  output logic [2:0]                err_code
);

  logic [2:0] code;
  place_e     place;
  logic       local_wb, busy, accept, err_q;
  logic [2:0] code_q;

  bitop_legality #(
    .CHIP_W(CHIP_W), .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W),
    .MAX_OPS(MAX_OPS), .OR_MAX_ROWS(OR_MAX_ROWS)
  ) u_legal (
    .op(req_op), .cnt(req_cnt), .srcs(req_srcs), .dst(req_dst),
    .code(code), .place(place), .local_wb(local_wb)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  bitop_seq #(.ADDR_W(ADDR_W), .MAX_OPS(MAX_OPS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept && (code == E_NONE)),
    .op(req_op), .cnt(req_cnt), .srcs(req_srcs), .dst(req_dst),
    .place(place), .local_wb(local_wb), .cmd_ready(cmd_ready),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_unit(cmd_unit), .cmd_addr(cmd_addr), .cmd_func(cmd_func),
    .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      code_q <= E_NONE;
    end else begin
      err_q  <= accept && (code != E_NONE);
      code_q <= accept ? code : E_NONE;
    end
  end

  assign err      = err_q;
  assign err_code = code_q;

endmodule

// File: rtl/bitop_dispatcher_chk.sv
module bitop_dispatcher_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_kind,
  input logic [1:0]        cmd_unit,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              done,
  input logic              err,
  input logic [2:0]        err_code
);

  assert_busy_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) &&
                                   $stable(cmd_unit) && $stable(cmd_addr)));

  assert_done_after_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid && cmd_ready));

  assert_done_err_apart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_err_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(req_valid && req_ready) && err_code != 3'd0));

  assert_err_no_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cmd_valid);

  assert_buffer_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_kind == 3'd4 || cmd_kind == 3'd5)) |-> cmd_unit != 2'd0);

endmodule

bind bitop_dispatcher bitop_dispatcher_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
  .cmd_unit(cmd_unit), .cmd_addr(cmd_addr), .done(done), .err(err),
  .err_code(err_code)
);

// File: tb/bitop_dispatcher_bench.sv
module bitop_dispatcher_bench;
  localparam int CHIP_W = 1, BANK_W = 2, SUB_W = 3, ROW_W = 4;
  localparam int MAX_OPS = 4, OR_MAX_ROWS = 3;
  localparam int ADDR_W = CHIP_W + BANK_W + SUB_W + ROW_W;
  localparam int CNT_W = $clog2(MAX_OPS + 1);
  localparam int TOP = ADDR_W - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, cmd_ready = 1'b0;
  logic [2:0] req_op = '0;
  logic [CNT_W-1:0] req_cnt = '0;
  logic [MAX_OPS*ADDR_W-1:0] req_srcs = '0;
  logic [ADDR_W-1:0] req_dst = '0;
  logic req_ready, cmd_valid, done, err;
  logic [2:0] cmd_kind, cmd_func, err_code;
  logic [1:0] cmd_unit;
  logic [ADDR_W-1:0] cmd_addr;

  always #2 clk = ~clk;

  bitop_dispatcher #(.CHIP_W(CHIP_W), .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W),
    .MAX_OPS(MAX_OPS), .OR_MAX_ROWS(OR_MAX_ROWS)) u_bitop_dispatcher (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_cnt(req_cnt), .req_srcs(req_srcs), .req_dst(req_dst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_unit(cmd_unit), .cmd_addr(cmd_addr), .cmd_func(cmd_func),
    .done(done), .err(err), .err_code(err_code));

  int checks = 0, fails = 0, cyc = 0;
  int e_kind [8], e_unit [8], e_addr [8], e_n;
  string e_req [8];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung actual=%0d expected=0", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [ADDR_W-1:0] mk(int c, int b, int s, int r);
    return {CHIP_W'(c), BANK_W'(b), SUB_W'(s), ROW_W'(r)};
  endfunction

  // R1: field extraction from the packed address
  function automatic int f_chip(logic [ADDR_W-1:0] a); return int'(a[TOP -: CHIP_W]); endfunction
  function automatic int f_bank(logic [ADDR_W-1:0] a); return int'(a[ROW_W+SUB_W +: BANK_W]); endfunction
  function automatic int f_sub(logic [ADDR_W-1:0] a);  return int'(a[ROW_W +: SUB_W]); endfunction

  function automatic int exp_code(int op, int cnt, logic [ADDR_W-1:0] s [MAX_OPS]);
    bit cnt_ok, xchip = 0, dupl = 0;
    if (op > 4) return 1;
    case (op)
      0, 4: cnt_ok = (cnt == 1);
      2, 3: cnt_ok = (cnt == 2);
      default: cnt_ok = (cnt >= 2 && cnt <= OR_MAX_ROWS);
    endcase
    if (!cnt_ok) return 2;
    for (int i = 1; i < cnt; i++) if (f_chip(s[i]) != f_chip(s[0])) xchip = 1;
    if (xchip) return 3;
    for (int i = 0; i < cnt; i++)
      for (int j = 0; j < i; j++) if (s[i] == s[j]) dupl = 1;
    return dupl ? 4 : 0;
  endfunction

  task automatic push(int k, int u, logic [ADDR_W-1:0] a, string r);
    e_kind[e_n] = k; e_unit[e_n] = u; e_addr[e_n] = int'(a); e_req[e_n] = r; e_n++;
  endtask

  task automatic build_exp(int op, int cnt, logic [ADDR_W-1:0] s [MAX_OPS], logic [ADDR_W-1:0] d);
    bit bdiff = 0, sdiff = 0, lwb;
    int u, wk;
    e_n = 0;
    for (int i = 1; i < cnt; i++) begin
      if (f_bank(s[i]) != f_bank(s[0])) bdiff = 1;
      if (f_sub(s[i]) != f_sub(s[0])) sdiff = 1;
    end
    lwb = !bdiff && !sdiff && (d[TOP:ROW_W] == s[0][TOP:ROW_W]);
    wk = lwb ? 6 : 7;
    if (!bdiff && !sdiff) begin
      if (op == 3) begin
        push(0, 0, s[0], "R5"); push(1, 0, s[0], "R5"); push(2, 0, s[0], "R5");
        push(0, 0, s[0], "R5"); push(1, 0, s[1], "R5"); push(3, 0, s[0], "R5");
      end else begin
        push(0, 0, s[0], "R4");
        for (int i = 0; i < cnt; i++) push(1, 0, s[i], "R4");
        push(3, 0, s[0], "R4");
      end
      push(wk, 0, d, "R8");
    end else begin
      u = bdiff ? 2 : 1;
      push(4, u, s[0], bdiff ? "R7" : "R6");
      for (int i = 1; i < cnt; i++) push(5, u, s[i], bdiff ? "R7" : "R6");
      push(wk, u, d, "R8");
    end
  endtask

  task automatic run_req(int op, int cnt, logic [ADDR_W-1:0] s [MAX_OPS], logic [ADDR_W-1:0] d);
    int code, idx, guard, pk, pa, pu;
    bit stall_prev, v;
    code = exp_code(op, cnt, s);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_cnt = CNT_W'(cnt); req_dst = d;
    for (int i = 0; i < MAX_OPS; i++) req_srcs[i*ADDR_W +: ADDR_W] = s[i];
    @(posedge clk); #1 req_valid = 1'b0;
    if (code != 0) begin
      @(negedge clk);
      chk(err == 1'b1, code == 1 ? "R2" : (code == 2 ? "R9" : "R3"), "err pulse", int'(err), 1);
      chk(int'(err_code) == code, code == 1 ? "R2" : (code == 2 ? "R9" : "R3"), "err_code", int'(err_code), code);
      chk(cmd_valid == 1'b0, "R3", "no command on reject", int'(cmd_valid), 0);
      @(negedge clk);
      chk(err == 1'b0, "R3", "err one cycle", int'(err), 0);
      return;
    end
    build_exp(op, cnt, s, d);
    idx = 0; guard = 0; stall_prev = 0; pk = 0; pa = 0; pu = 0;
    while (idx < e_n && guard < 400) begin
      @(negedge clk);
      guard++;
      cmd_ready = ($urandom % 3) != 0;
      v = cmd_valid;
      if (idx == 0 && guard == 1) begin
        chk(req_ready == 1'b0, "R10", "ready low while busy", int'(req_ready), 0);
        chk(err == 1'b0, "R3", "no err on legal", int'(err), 0);
      end
      if (stall_prev)
        chk(v && int'(cmd_kind) == pk && int'(cmd_addr) == pa && int'(cmd_unit) == pu,
            "R11", "stalled command held", int'(cmd_kind), pk);
      if (v && cmd_ready) begin
        chk(int'(cmd_kind) == e_kind[idx], e_req[idx], "cmd_kind", int'(cmd_kind), e_kind[idx]);
        chk(int'(cmd_addr) == e_addr[idx], e_req[idx], "cmd_addr", int'(cmd_addr), e_addr[idx]);
        chk(int'(cmd_unit) == e_unit[idx], e_req[idx], "cmd_unit", int'(cmd_unit), e_unit[idx]);
        chk(int'(cmd_func) == op, e_req[idx], "cmd_func", int'(cmd_func), op);
        chk(idx == e_n - 1 || done == 1'b0, "R12", "done early", int'(done), 0);
        idx++;
      end
      stall_prev = v && !cmd_ready;
      pk = int'(cmd_kind); pa = int'(cmd_addr); pu = int'(cmd_unit);
    end
    chk(idx == e_n, "R10", "commands issued", idx, e_n);
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(done == 1'b1, "R12", "done pulse", int'(done), 1);
    chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R10", "idle after last", int'(req_ready), 1);
    @(negedge clk);
    chk(done == 1'b0, "R12", "done one cycle", int'(done), 0);
  endtask

  initial begin
    logic [ADDR_W-1:0] s [MAX_OPS];
    logic [ADDR_W-1:0] d;
    int op, cnt, mode, c0, b0, s0, r0, seed;
    seed = $urandom(32'h1b17);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R10", "reset ready/valid", int'(req_ready), 1);
    chk(done == 1'b0 && err == 1'b0 && err_code == 3'd0, "R12", "reset pulses", int'(err_code), 0);
    rst_n = 1'b1;

    // directed corners
    s = '{mk(0,1,2,3), mk(0,1,2,5), mk(0,1,2,9), mk(0,1,2,0)};
    run_req(1, 3, s, mk(0,1,2,12));        // R4 intra OR, in-place R8
    run_req(1, 4, s, mk(0,1,2,12));        // R9 OR beyond limit
    run_req(2, 3, s, mk(0,1,2,12));        // R9 wide AND rejected
    run_req(3, 2, s, mk(0,2,2,1));         // R5 XOR, bus write R8
    run_req(0, 1, s, mk(0,1,2,7));         // R4 READ
    run_req(4, 0, s, mk(0,1,2,7));         // R9 zero operands
    s = '{mk(0,3,1,4), mk(0,3,6,4), mk(0,3,2,8), mk(0,0,0,0)};
    run_req(2, 2, s, mk(0,3,1,4));         // R6 inter-subarray, R8 bus
    run_req(1, 3, s, mk(0,3,1,2));         // R6
    s = '{mk(0,0,1,4), mk(0,2,1,4), mk(0,1,5,8), mk(0,0,0,0)};
    run_req(1, 3, s, mk(0,0,1,1));         // R7 inter-bank
    s = '{mk(0,0,1,4), mk(1,0,1,4), mk(0,0,1,4), mk(0,0,0,0)};
    run_req(1, 3, s, mk(0,0,1,1));         // R3 cross-chip beats duplicate
    run_req(6, 3, s, mk(0,0,1,1));         // R2 bad opcode beats all
    s = '{mk(1,2,3,4), mk(1,2,3,4), mk(0,0,0,0), mk(0,0,0,0)};
    run_req(2, 2, s, mk(1,2,3,5));         // R3 same row

    // random traffic; R1 field placement exercised by random addresses
    for (int n = 0; n < 300; n++) begin
      op = ($urandom % 5 == 0) ? int'($urandom % 8) : int'($urandom % 5);
      case (op)
        0, 4: cnt = 1;
        2, 3: cnt = 2;
        default: cnt = 2 + int'($urandom % 3);
      endcase
      if ($urandom % 5 == 0) cnt = int'($urandom % (MAX_OPS + 1));
      c0 = $urandom; b0 = $urandom; s0 = $urandom; r0 = $urandom;
      mode = $urandom % 6;
      for (int i = 0; i < MAX_OPS; i++) begin
        case (mode)
          2: s[i] = mk(c0, b0, s0 + i, $urandom);
          3: s[i] = mk(c0, b0 + i, $urandom, $urandom);
          4: s[i] = ADDR_W'($urandom);
          default: s[i] = mk(c0, b0, s0, r0 + i);
        endcase
      end
      if (mode == 5 && cnt > 1) s[cnt-1] = s[0];
      d = ($urandom % 2) ? mk(c0, b0, s0, $urandom) : ADDR_W'($urandom);
      run_req(op, cnt, s, d);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule